// File: doc/BRIEF.md
# Two-Wire Serial Flash Read Sequencer

This block is a host-side master for a two-wire serial programming port: a clock line that the host always drives, and one data line that the host drives or releases. A single start pulse, with a 22-bit start address and a byte count, reads that many consecutive bytes from the target's program memory space. The block first sends six core-instruction frames. These place each address byte in the target's working register and then store it into one of the three bytes of the target's address pointer. It then sends one read-with-post-increment frame per byte. The target advances its own pointer after each read, so the pointer is loaded only once per request.

Every frame has 20 clock pulses. The first four carry a command code, least significant bit first. The other sixteen carry an operand or return data. In a read frame, the host releases the data line after the eighth operand pulse and holds the clock low for a turnaround gap. It then samples eight returned bits on the falling clock edges. Each byte goes out on a valid/ready stream. If the consumer is slow, the block waits in the gap between frames, never inside one. A one-cycle done pulse follows the last byte.

The clock half-period and the turnaround gap are both parameters counted in system clocks. The valid address range is 0x000000 to 0x3FFFFF, which covers program memory, ID locations and configuration bytes.

Top module: `flash_rd_seq`

## Requirements
- R1: While reset is asserted, the port clock is low, the data line is driven (output enable high) with value 0, out_valid is low and done is low.
- R2: Each frame has 20 port clock pulses, and every high phase and every ordinary low phase lasts HALF_CYC system clocks. The host changes its data bit when the clock rises, and the target takes it on the falling edge. Bits 0 to 3 of a frame carry the command, least significant bit first, and bits 4 to 19 carry the operand, least significant bit first.
- R3: A request with a nonzero count starts with six frames using command 0000 (core instruction). Their operands are, in order: 0x0E followed by {2'b00, addr[21:16]}, 0x6EF8, 0x0E followed by addr[15:8], 0x6EF7, 0x0E followed by addr[7:0], and 0x6EF6. In each case the first byte named is the operand's upper byte.
- R4: After the six pointer-load frames come exactly byte_count frames using command 1001 (read with post-increment), with no pointer reload between them. In each one, the byte returned in bits 12 to 19 is sampled least significant bit first on the falling clock edges and becomes the next stream byte.
- R5: In a read frame, after the falling edge of bit 11, the clock stays low for HALF_CYC + TURN_CYC system clocks before bit 12 rises. Output enable is low from the start of that turnaround until the frame ends, and high at every other time.
- R6: Once out_valid is high, out_valid and out_data stay stable until out_ready is seen high. Bytes come out in ascending address order.
- R7: While a byte waits for acceptance, the port clock stays low with no edges and the data line stays driven.
- R8: done pulses for exactly one cycle, in the cycle after the last byte is accepted. A start with byte_count zero produces the done pulse in the next cycle, and no frame is sent.
- R9: A start pulse that arrives while a request is in progress is ignored: the running request finishes unchanged, and no further frames follow it.
- R10: A start pulse that arrives in the same cycle as done is accepted and begins a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| start_addr | input | 22 | First byte address of the request |
| byte_count | input | CNT_W | Number of bytes to read |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Consumer accepts the stream byte |
| out_data | output | 8 | Stream byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| pgm_clk | output | 1 | Port clock line |
| pgm_dout | output | 1 | Value driven on the data line |
| pgm_oe | output | 1 | Data line output enable, high when the host drives |
| pgm_din | input | 1 | Value read from the data line |

## Verification
The end-of-request done pulse and the acceptance of a new start request can fall in the same cycle, because done is raised in the idle state where start is sampled. The bench provokes this by raising start in the very cycle it observes done at the end of a one-byte request. It then judges the second request by its six pointer-load operands, which must match the new address, and by its returned bytes and read-frame count. A second overlap, a start pulse during a transfer, is provoked just after the first byte is accepted. It is judged by the unchanged byte sequence and by silence on the port after done.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
   localparam int FRAME_BITS   = 20;
   localparam int OPND_BITS    = 16;
   localparam int ADDR_BITS    = 22;
   localparam int RX_FIRST_BIT = 12;
   localparam int TURN_BIT_IDX = 11;

   localparam logic [3:0] CMD_CORE = 4'b0000;
   localparam logic [3:0] CMD_RDINC = 4'b1001;

   localparam logic [7:0] OPC_LIT   = 8'h0E;
   localparam logic [7:0] OPC_STORE = 8'h6E;
   localparam logic [7:0] REG_UPPER = 8'hF8;
   localparam logic [7:0] REG_HIGH  = 8'hF7;
   localparam logic [7:0] REG_LOW   = 8'hF6;

   localparam logic [2:0] STEP_READ = 3'd6;

   typedef enum logic [1:0] {ENG_IDLE, ENG_HIGH, ENG_LOW, ENG_TURN} eng_state_t;
   typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_HOLD} seq_state_t;
endpackage

// File: rtl/prog_frame_fmt.sv
module prog_frame_fmt
   import flash_rd_pkg::*;
(
   input  logic [2:0]            step,
   input  logic [ADDR_BITS-1:0]  addr,
   output logic [FRAME_BITS-1:0] frame,
   output logic                  is_read
);
   logic [OPND_BITS-1:0] opnd;
   logic [3:0]           cmd;

   always_comb begin
      cmd     = CMD_CORE;
      is_read = 1'b0;
      unique case (step)
         3'd0:    opnd = {OPC_LIT, 2'b00, addr[21:16]};
         3'd1:    opnd = {OPC_STORE, REG_UPPER};
         3'd2:    opnd = {OPC_LIT, addr[15:8]};
         3'd3:    opnd = {OPC_STORE, REG_HIGH};
         3'd4:    opnd = {OPC_LIT, addr[7:0]};
         3'd5:    opnd = {OPC_STORE, REG_LOW};
         default: begin
            opnd    = '0;
            cmd     = CMD_RDINC;
            is_read = 1'b1;
         end
      endcase
      frame = {opnd, cmd};
   end
endmodule

// File: rtl/prog_frame_engine.sv
module prog_frame_engine
   import flash_rd_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int TURN_CYC = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic                  is_read,
   input  logic                  pdi,
   output logic                  fin,
   output logic [7:0]            rbyte,
   output logic                  pclk,
   output logic                  pdo,
   output logic                  poe
);
   localparam int MAXC = (HALF_CYC > TURN_CYC) ? HALF_CYC : TURN_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int BW   = $clog2(FRAME_BITS);
   localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);
   localparam logic [CW-1:0] TURN_LD  = CW'(TURN_CYC - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
   localparam logic [BW-1:0] TURN_BIT = BW'(TURN_BIT_IDX);
   localparam logic [BW-1:0] RX_FIRST = BW'(RX_FIRST_BIT);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("TURN_CYC must be at least 1");
      end
   endgenerate

   eng_state_t            st;
   logic [CW-1:0]         cnt;
   logic [BW-1:0]         bi;
   logic [FRAME_BITS-1:0] sh;
   logic                  rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ENG_IDLE;
         cnt   <= '0;
         bi    <= '0;
         sh    <= '0;
         rd    <= 1'b0;
         rbyte <= '0;
         pclk  <= 1'b0;
         pdo   <= 1'b0;
         poe   <= 1'b1;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (st)
            ENG_IDLE: if (start) begin
               sh   <= frame_in;
               rd   <= is_read;
               bi   <= '0;
               cnt  <= HALF_LD;
               pclk <= 1'b1;
               pdo  <= frame_in[0];
               st   <= ENG_HIGH;
            end
            ENG_HIGH: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
               pclk <= 1'b0;
               cnt  <= HALF_LD;
               st   <= ENG_LOW;
               if (rd && bi >= RX_FIRST) rbyte <= {pdi, rbyte[7:1]};
            end
            ENG_LOW: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (bi == LAST_BIT) begin
               st  <= ENG_IDLE;
               fin <= 1'b1;
               poe <= 1'b1;
               pdo <= 1'b0;
            end else if (rd && bi == TURN_BIT) begin
               st  <= ENG_TURN;
               poe <= 1'b0;
               cnt <= TURN_LD;
            end else begin
               bi   <= bi + 1'b1;
               pdo  <= sh[bi + 1'b1];
               pclk <= 1'b1;
               cnt  <= HALF_LD;
               st   <= ENG_HIGH;
            end
            ENG_TURN: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
               bi   <= bi + 1'b1;
               pdo  <= 1'b0;
               pclk <= 1'b1;
               cnt  <= HALF_LD;
               st   <= ENG_HIGH;
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   // R5
   idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ENG_IDLE |-> poe);
   // R5
   turn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ENG_TURN |-> (!pclk && !poe));
   // R4
   rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !poe |-> rd);
   // R2
   high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ENG_HIGH |-> pclk);
endmodule

// File: rtl/prog_byte_slot.sv
module prog_byte_slot #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         out_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         taken
);
   generate
      if (W < 1) begin : g_bad_w
         $error("W must be at least 1");
      end
   endgenerate

   assign taken = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= din;
      end else if (taken) begin
         out_valid <= 1'b0;
      end
   end

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R6
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
   import flash_rd_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int TURN_CYC = 2 * HALF_CYC,
   parameter int CNT_W    = 8
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [21:0]          start_addr,
   input  logic [CNT_W-1:0]     byte_count,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [7:0]           out_data,
   output logic                 done,
   output logic                 pgm_clk,
   output logic                 pgm_dout,
   output logic                 pgm_oe,
   input  logic                 pgm_din
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   seq_state_t            sq;
   logic [2:0]            step;
   logic [ADDR_BITS-1:0]  addr_q;
   logic [CNT_W-1:0]      remain;
   logic [FRAME_BITS-1:0] frame;
   logic                  is_read;
   logic                  eng_start, eng_fin, slot_load, taken;
   logic [7:0]            rbyte;

   assign eng_start = (sq == SQ_ISSUE);
   assign slot_load = (sq == SQ_WAIT) && eng_fin && (step == STEP_READ);

   prog_frame_fmt i_fmt (
      .step(step), .addr(addr_q), .frame(frame), .is_read(is_read));

   prog_frame_engine #(.HALF_CYC(HALF_CYC), .TURN_CYC(TURN_CYC)) i_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .frame_in(frame),
      .is_read(is_read), .pdi(pgm_din), .fin(eng_fin), .rbyte(rbyte),
      .pclk(pgm_clk), .pdo(pgm_dout), .poe(pgm_oe));

   prog_byte_slot #(.W(8)) i_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_load), .din(rbyte),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .taken(taken));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq     <= SQ_IDLE;
         step   <= '0;
         addr_q <= '0;
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (sq)
            SQ_IDLE: if (start) begin
               if (byte_count == '0) done <= 1'b1;
               else begin
                  addr_q <= start_addr;
                  remain <= byte_count;
                  step   <= '0;
                  sq     <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: sq <= SQ_WAIT;
            SQ_WAIT: if (eng_fin) begin
               if (step != STEP_READ) begin
                  step <= step + 1'b1;
                  sq   <= SQ_ISSUE;
               end else begin
                  remain <= remain - 1'b1;
                  sq     <= SQ_HOLD;
               end
            end
            SQ_HOLD: if (taken) begin
               if (remain == '0) begin
                  sq   <= SQ_IDLE;
                  done <= 1'b1;
               end else sq <= SQ_ISSUE;
            end
            default: sq <= SQ_IDLE;
         endcase
      end
   end

   // R7
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!pgm_clk && pgm_oe));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq != SQ_IDLE) |=> $stable(addr_q));
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!out_valid && pgm_oe && !pgm_clk));
endmodule

// File: tb/test_flash_rd_seq.sv
module test_flash_rd_seq;
   localparam int HALF = 2;
   localparam int TURN = 4;
   localparam int CW   = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0, pgm_din = 1'b0;
   logic [21:0] start_addr = '0;
   logic [CW-1:0] byte_count = '0;
   logic out_valid, done, pgm_clk, pgm_dout, pgm_oe;
   logic [7:0] out_data;

   int total = 0, bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   flash_rd_seq #(.HALF_CYC(HALF), .TURN_CYC(TURN), .CNT_W(CW)) i_flash_rd_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done(done), .pgm_clk(pgm_clk), .pgm_dout(pgm_dout),
      .pgm_oe(pgm_oe), .pgm_din(pgm_din));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] tmem(input logic [21:0] a);
      return a[7:0] ^ a[13:6] ^ {2'b00, a[21:16]} ^ 8'hA5;
   endfunction

   function automatic logic [15:0] core_exp(input int idx, input logic [21:0] a);
      case (idx)
         0: return {8'h0E, 2'b00, a[21:16]};
         1: return 16'h6EF8;
         2: return {8'h0E, a[15:8]};
         3: return 16'h6EF7;
         4: return {8'h0E, a[7:0]};
         5: return 16'h6EF6;
         default: return 16'hFFFF;
      endcase
   endfunction

   // target model
   logic prev_clk = 1'b0;
   int run = 0, fb = 0, edges = 0, core_frames = 0, read_frames = 0, core_idx = 0;
   logic [19:0] fbits = '0;
   logic [21:0] ptr = '0, exp_base = '0;
   logic [7:0]  wreg = '0, tbyte = '0;
   logic [3:0]  tcmd = '0;
   logic [15:0] op = '0;

   always @(negedge clk) if (rst_n) begin
      if (pgm_clk != prev_clk) begin
         edges++;
         if (pgm_clk) begin
            if (fb == 12 && tcmd == 4'b1001)
               chk(run == HALF + TURN, "R5", "turnaround low cycles", run, HALF + TURN);
            else if (fb != 0)
               chk(run == HALF, "R2", "low phase cycles", run, HALF);
            if (tcmd == 4'b1001 && fb >= 12) begin
               chk(!pgm_oe, "R5", "oe while target drives", pgm_oe, 0);
               pgm_din <= tbyte[fb-12];
            end
         end else begin
            chk(run == HALF, "R2", "high phase cycles", run, HALF);
            chk(pgm_oe == !(fb >= 12 && tcmd == 4'b1001), "R5", "oe at falling edge",
                pgm_oe, !(fb >= 12 && tcmd == 4'b1001));
            fbits[fb] = pgm_dout;
            fb++;
            if (fb == 4) begin
               tcmd = fbits[3:0];
               if (tcmd == 4'b1001) tbyte = tmem(ptr);
            end
            if (fb == 20) begin
               if (tcmd == 4'b1001) begin
                  read_frames++;
                  ptr = ptr + 22'd1;
                  core_idx = 0;
               end else begin
                  op = fbits[19:4];
                  chk(tcmd == 4'b0000, "R3", "command code", tcmd, 0);
                  chk(op == core_exp(core_idx, exp_base), "R3", "core operand",
                      op, core_exp(core_idx, exp_base));
                  core_frames++;
                  if (op[15:8] == 8'h0E) wreg = op[7:0];
                  else case (op[7:0])
                     8'hF8: ptr[21:16] = wreg[5:0];
                     8'hF7: ptr[15:8]  = wreg;
                     8'hF6: ptr[7:0]   = wreg;
                     default: ;
                  endcase
                  core_idx++;
               end
               fb = 0;
               tcmd = '0;
               pgm_din <= 1'b0;
            end
         end
         run = 1;
      end else run++;
      prev_clk = pgm_clk;
   end

   task automatic do_collect(input logic [21:0] a, input int n, input int mode,
                             input bit inj, input string req);
      int got = 0;
      int c0 = core_frames, r0 = read_frames;
      bit seen = 0;
      logic [7:0] d0;
      int e0;
      out_ready = (mode == 0);
      for (int i = 0; i < 20000 && !seen; i++) begin
         @(negedge clk);
         start = 1'b0;
         if (mode == 1) out_ready = 1'b0;
         if (out_valid) begin
            if (mode == 1) begin
               d0 = out_data;
               e0 = edges;
               repeat (4) @(negedge clk);
               chk(out_valid && out_data == d0, "R6", "byte held while not ready", out_data, d0);
               chk(edges == e0 && !pgm_clk && pgm_oe, "R7", "port edges during stall", edges - e0, 0);
               out_ready = 1'b1;
            end
            chk(out_data == tmem(a + 22'(got)), "R4", "returned byte", out_data, tmem(a + 22'(got)));
            got++;
            if (inj && got == 1) begin
               start_addr = 22'h155555;
               byte_count = 8'd1;
               start = 1'b1;
            end
         end
         if (done) begin
            seen = 1;
            chk(got == n, "R8", "bytes before done", got, n);
         end
      end
      chk(seen, "R8", "done seen", seen, 1);
      chk(core_frames - c0 == 6, req, "pointer-load frames", core_frames - c0, 6);
      chk(read_frames - r0 == n, req, "read frames", read_frames - r0, n);
   endtask

   task automatic t_xfer(input logic [21:0] a, input int n, input int mode, input bit inj);
      int e0;
      exp_base = a;
      start_addr = a;
      byte_count = CW'(n);
      start = 1'b1;
      do_collect(a, n, mode, inj, "R3");
      @(negedge clk);
      chk(!done, "R8", "done one cycle", done, 0);
      if (inj) begin
         e0 = edges;
         repeat (40) @(negedge clk);
         chk(edges == e0, "R9", "no frames after ignored start", edges - e0, 0);
      end
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!pgm_clk && pgm_oe && !pgm_dout, "R1", "port lines in reset",
          {pgm_clk, pgm_oe, pgm_dout}, 3'b010);
      chk(!out_valid && !done, "R1", "stream and done in reset", {out_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_zero();
      int e0 = edges;
      start_addr = 22'h000100;
      byte_count = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done, "R8", "done for zero count", done, 1);
      @(negedge clk);
      chk(!done, "R8", "zero count done one cycle", done, 0);
      repeat (20) @(negedge clk);
      chk(edges == e0, "R8", "no frames for zero count", edges - e0, 0);
   endtask

   task automatic t_chain();
      exp_base = 22'h000000;
      start_addr = 22'h000000;
      byte_count = 8'd1;
      start = 1'b1;
      do_collect(22'h000000, 1, 0, 0, "R4");
      // R10: start raised in the cycle done is high
      exp_base = 22'h2A0F10;
      start_addr = 22'h2A0F10;
      byte_count = 8'd2;
      start = 1'b1;
      do_collect(22'h2A0F10, 2, 0, 0, "R10");
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_xfer(22'h012345, 4, 0, 0);
      t_xfer(22'h00FFFE, 5, 1, 0);
      t_xfer(22'h3FFFFD, 3, 0, 1);
      t_zero();
      t_chain();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule